// File: doc/BRIEF.md
# Hybrid LFSR / Binary 64-bit Counter

This block is a free-running up-counter meant for high count rates. Its 64-bit value is split into two parts. The 8 low-order bits come from a shift-register sequence generator whose feedback has been extended so that it passes through all 256 states, including all-zero. The 56 high-order bits form a plain synchronous binary counter that steps once for each full pass of the low part. Only the low part toggles on every cycle, and a shift register has one XOR level ahead of each flop, so the fast path stays short. The wide binary part moves only once every 256 enabled cycles, and its increment enable is taken straight from a flop.

The raw low-part state is made available. A table computed at elaboration turns that state into its position in the sequence, which is the number of enabled steps since the seed. The readable count is the high part followed by that position. A registered terminal-count flag goes high while the count is all ones. The block has only control pins: clock, synchronous reset and count enable. There is no data stream, so there is no handshake.

Top module: `hybrid_lfsr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `lfsr_state` = 8'h01 (the seed), `hi_count` = 0, `count` = 0 and `term_cnt` = 0.
- R2: Each rising edge with `cnt_en` high and `rst` low raises `count` by exactly one, modulo 2^(8+HI_W).
- R3: A rising edge with `cnt_en` low and `rst` low leaves `lfsr_state`, `hi_count`, `count` and `term_cnt` unchanged.
- R4: On an enabled edge the low state s becomes {s[6:0], f}. Here f = s[7]^s[5]^s[4]^s[3] (polynomial x^8+x^6+x^5+x^4+1), inverted when s[6:0] is all zero. This gives the run 8'h80 -> 8'h00 -> 8'h01.
- R5: Over any 256 consecutive enabled steps that start from count low byte 0, each of the 256 values of `lfsr_state` appears exactly once.
- R6: `count[7:0]` equals the number of enabled steps since the low state last held the seed, modulo 256.
- R7: `hi_count` rises by one exactly on the enabled edge where `lfsr_state` goes from 8'h00 to 8'h01, and it holds on every other edge.
- R8: `term_cnt` is high exactly while `count` is all ones. It changes on the same edge as `count`.
- R9: From all ones, one enabled edge returns `count` to 0 and drops `term_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance the count on this edge |
| lfsr_state | output | 8 | Raw state of the low sequence generator |
| hi_count | output | HI_W | High-order binary part (56 by default) |
| count | output | 8+HI_W | Full binary count {hi_count, sequence position} |
| term_cnt | output | 1 | Registered flag, high while count is all ones |

## Verification
The assertions assume that `cnt_en` and `rst` are stable around the rising edge and are never unknown after time zero. They also assume that reset is applied at the first edge, so every `$past` value comes from a reset or counting cycle. The bench drives both pins one time unit after each edge and holds reset from time zero. A reduced instance with a 2-bit high part reaches the all-ones value within about a thousand cycles. That lets the terminal flag and the wrap be seen on real edges, which is not possible with the 64-bit default.

// File: rtl/hlc_pkg.sv
package hlc_pkg;
  // width of the low shift-register part
  localparam int unsigned LO_W = 8;
  // number of states the extended low part cycles through
  localparam int unsigned LO_N = 2 ** LO_W;
  // feedback tap mask: bits 7,5,4,3 (x^8+x^6+x^5+x^4+1)
  localparam logic [LO_W-1:0] LO_TAPS = 8'hB8;
  // state that represents count 0
  localparam logic [LO_W-1:0] LO_SEED = 8'h01;

  // one step of the extended sequence
  function automatic logic [LO_W-1:0] lo_step(input logic [LO_W-1:0] s);
    logic fb;
    fb = ^(s & LO_TAPS);
    if (s[LO_W-2:0] == '0) fb = ~fb;
    return {s[LO_W-2:0], fb};
  endfunction

  // state reached after LO_N-1 steps from the seed
  function automatic logic [LO_W-1:0] lo_last_state();
    logic [LO_W-1:0] s;
    s = LO_SEED;
    for (int i = 0; i < int'(LO_N) - 1; i++) s = lo_step(s);
    return s;
  endfunction

  localparam logic [LO_W-1:0] LO_LAST = lo_last_state();
endpackage

// File: rtl/hlc_lfsr_ext.sv
module hlc_lfsr_ext
  import hlc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [LO_W-1:0] state,
  output logic            at_last,
  output logic            pre_last
);
  logic [LO_W-1:0] state_q;
  logic [LO_W-1:0] state_nx;
  logic            at_last_q;

  assign state_nx = lo_step(state_q);
  // next state is the last one of the period
  assign pre_last = (state_nx == LO_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LO_SEED;
      at_last_q <= 1'b0;
    end else if (en) begin
      state_q   <= state_nx;
      at_last_q <= pre_last;
    end
  end

  assign state   = state_q;
  assign at_last = at_last_q;

  // R7
  at_last_track_chk: assert property (@(posedge clk) disable iff (rst)
    at_last_q == (state_q == LO_LAST));

  // R4
  zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == 8'h80) |=> state_q == 8'h00);
endmodule

// File: rtl/hlc_state_index.sv
module hlc_state_index
  import hlc_pkg::*;
(
  input  logic [LO_W-1:0] state,
  output logic [LO_W-1:0] idx
);
  localparam int unsigned TBL_W = LO_N * LO_W;

  // inverse of the sequence: entry for a state holds its step number
  function automatic logic [TBL_W-1:0] build_map();
    logic [TBL_W-1:0] t;
    logic [LO_W-1:0]  s;
    t = '0;
    s = LO_SEED;
    for (int i = 0; i < int'(LO_N); i++) begin
      t[int'(s)*LO_W +: LO_W] = i[LO_W-1:0];
      s = lo_step(s);
    end
    return t;
  endfunction

  localparam logic [TBL_W-1:0] MAP = build_map();

  assign idx = MAP[int'(state)*LO_W +: LO_W];
endmodule

// File: rtl/hlc_high_ctr.sv
module hlc_high_ctr #(
  parameter int unsigned HI_W = 56
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            lo_last,
  input  logic            lo_pre_last,
  output logic [HI_W-1:0] hi,
  output logic            tc
);
  localparam logic [HI_W-1:0] HI_PEN = {HI_W{1'b1}} ^ HI_W'(1);

  logic [HI_W-1:0] hi_q;
  logic            hi_top_q;
  logic            tc_q;
  logic            inc;

  // both operands come straight from flops
  assign inc = en & lo_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      hi_top_q <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      if (inc) begin
        hi_q     <= hi_q + HI_W'(1);
        hi_top_q <= (hi_q == HI_PEN);
      end
      if (en) tc_q <= lo_pre_last & hi_top_q;
    end
  end

  assign hi = hi_q;
  assign tc = tc_q;

  // R7
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> hi_q == $past(hi_q) + HI_W'(1));

  // R7
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(hi_q));

  // R8
  tc_top_chk: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (&hi_q && lo_last));
endmodule

// File: rtl/hybrid_lfsr_counter.sv
module hybrid_lfsr_counter
  import hlc_pkg::*;
#(
  parameter int unsigned HI_W = 56
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cnt_en,
  output logic [LO_W-1:0]      lfsr_state,
  output logic [HI_W-1:0]      hi_count,
  output logic [LO_W+HI_W-1:0] count,
  output logic                 term_cnt
);
  localparam int unsigned CNT_W = LO_W + HI_W;

  logic [LO_W-1:0] lo_state;
  logic [LO_W-1:0] lo_idx;
  logic            lo_last;
  logic            lo_pre_last;
  logic [HI_W-1:0] hi_val;
  logic            tc_val;

  hlc_lfsr_ext u_lo (
    .clk      (clk),
    .rst      (rst),
    .en       (cnt_en),
    .state    (lo_state),
    .at_last  (lo_last),
    .pre_last (lo_pre_last)
  );

  hlc_state_index u_idx (
    .state (lo_state),
    .idx   (lo_idx)
  );

  hlc_high_ctr #(.HI_W(HI_W)) u_hi (
    .clk         (clk),
    .rst         (rst),
    .en          (cnt_en),
    .lo_last     (lo_last),
    .lo_pre_last (lo_pre_last),
    .hi          (hi_val),
    .tc          (tc_val)
  );

  assign lfsr_state = lo_state;
  assign hi_count   = hi_val;
  assign count      = {hi_val, lo_idx};
  assign term_cnt   = tc_val;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> count == $past(count) + CNT_W'(1));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(count) && $stable(lfsr_state) && $stable(term_cnt)));

  // R8
  tc_match_chk: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (&count));
endmodule

// File: tb/hybrid_lfsr_counter_tb_top.sv
`timescale 1ns/1ps
module hybrid_lfsr_counter_tb_top;
  localparam int unsigned W_HI = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic        w_en = 1'b0;
  logic [7:0]  lfsr_state;
  logic [55:0] hi_count;
  logic [63:0] count;
  logic        term_cnt;
  logic [7:0]      w_lfsr;
  logic [W_HI-1:0] w_hi;
  logic [7+W_HI:0] w_cnt;
  logic            w_tc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hybrid_lfsr_counter dut_i (
    .clk(clk), .rst(rst), .cnt_en(en),
    .lfsr_state(lfsr_state), .hi_count(hi_count),
    .count(count), .term_cnt(term_cnt));

  hybrid_lfsr_counter #(.HI_W(W_HI)) wrap_i (
    .clk(clk), .rst(rst), .cnt_en(w_en),
    .lfsr_state(w_lfsr), .hi_count(w_hi),
    .count(w_cnt), .term_cnt(w_tc));

  // {en, expected count low byte after the edge}, from reset
  localparam logic [8:0] VEC [12] = '{
    {1'b1, 8'd1}, {1'b1, 8'd2}, {1'b0, 8'd2}, {1'b1, 8'd3},
    {1'b0, 8'd3}, {1'b0, 8'd3}, {1'b1, 8'd4}, {1'b1, 8'd5},
    {1'b1, 8'd6}, {1'b0, 8'd6}, {1'b1, 8'd7}, {1'b1, 8'd8}};

  // sequence rule from R4
  function automatic logic [7:0] ref_next(input logic [7:0] s);
    logic f;
    f = s[7] ^ s[5] ^ s[4] ^ s[3];
    if (s[6:0] == 7'd0) f = ~f;
    return {s[6:0], f};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] rc;
    logic [7:0]  rl;
    logic [7:0]  prev_l;
    logic [55:0] prev_h;
    int occ [256];

    // reset state R1
    rst = 1'b1;
    cyc(); cyc();
    chk(count == 64'd0, "R1 count", count, 0);
    chk(lfsr_state == 8'h01, "R1 seed", lfsr_state, 8'h01);
    chk(hi_count == 56'd0, "R1 hi", hi_count, 0);
    chk(term_cnt == 1'b0, "R1 tc", term_cnt, 0);
    rst = 1'b0;

    // vector table: R2, R3, R6
    rl = 8'h01;
    foreach (VEC[i]) begin
      en = VEC[i][8];
      cyc();
      if (VEC[i][8]) rl = ref_next(rl);
      chk(count == {56'd0, VEC[i][7:0]}, "R6 table count", count, {56'd0, VEC[i][7:0]});
      chk(lfsr_state == rl, "R4 table state", lfsr_state, rl);
    end
    en = 1'b0;

    // R3: hold across several idle edges
    prev_l = lfsr_state;
    cyc(); cyc(); cyc();
    chk(count == 64'd8, "R3 idle count", count, 8);
    chk(lfsr_state == prev_l, "R3 idle state", lfsr_state, prev_l);

    // R1: reset with enable high
    en = 1'b1; rst = 1'b1;
    cyc();
    chk(count == 64'd0, "R1 reset over enable", count, 0);
    rst = 1'b0;

    // long run: R2 R4 R5 R7
    foreach (occ[i]) occ[i] = 0;
    occ[8'h01] = 1;
    rc = 64'd0;
    rl = 8'h01;
    for (int k = 0; k < 3 * 256 + 40; k++) begin
      en     = (k % 37 != 36);
      prev_l = lfsr_state;
      prev_h = hi_count;
      cyc();
      if (en) begin
        rc = rc + 64'd1;
        rl = ref_next(rl);
        occ[lfsr_state]++;
      end
      chk(count == rc, "R2 count", count, rc);
      chk(lfsr_state == rl, "R4 state", lfsr_state, rl);
      chk(hi_count == rc[63:8], "R7 hi", {8'd0, hi_count}, {8'd0, rc[63:8]});
      if (en && prev_l == 8'h00)
        chk(hi_count == prev_h + 56'd1, "R7 hi step", {8'd0, hi_count}, {8'd0, prev_h + 56'd1});
      if (en && rc[7:0] == 8'hFF) begin
        for (int s = 0; s < 256; s++) begin
          if (occ[s] != 1) chk(1'b0, "R5 occupancy", 64'(occ[s]), 1);
          occ[s] = 0;
        end
        chk(1'b1, "R5 period", 0, 0);
      end
    end
    en = 1'b0;

    // wrap instance: R8 R9
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    w_en = 1'b1;
    for (int k = 1; k <= 1023; k++) begin
      cyc();
      chk(w_tc == (k == 1023), "R8 tc", 64'(w_tc), 64'(k == 1023));
    end
    chk(w_cnt == 10'h3FF, "R8 all ones", 64'(w_cnt), 64'h3FF);
    cyc();
    chk(w_cnt == 10'd0, "R9 wrap count", 64'(w_cnt), 0);
    chk(w_tc == 1'b0, "R9 tc drop", 64'(w_tc), 0);
    chk(w_lfsr == 8'h01, "R9 seed", 64'(w_lfsr), 1);
    w_en = 1'b0;
    cyc();
    chk(w_cnt == 10'd0, "R3 hold after wrap", 64'(w_cnt), 0);

    finish_run();
  end
endmodule